// File: doc/BRIEF.md
# Hardware Transaction State and Failure Controller

This block keeps the transactional state of one hardware thread. A small command port delivers begin, end, abort (three forms), suspend, resume and check operations, each tagged with its instruction address. The block tracks whether the thread is outside a transaction, inside one, or inside one that is suspended. It also keeps a flat nesting depth. It answers every command one cycle later with a 4-bit condition result.

Failures come from two places. Commands can cause them: explicit aborts, conditional aborts whose comparison holds, and nesting overflow. Footprint tracking and the rest of the core can also signal them on an event input. On the first failure the block latches a status word: the cause, a hint on whether retrying is pointless, and an 8-bit software code. It also latches the failing address. Inside a transaction it unwinds to the outermost level at once and requests a redirect to the handler, which is the outermost begin address plus 4. While the transaction is suspended, the failure is only recorded. The redirect waits for the resume.

Top module: `txn_ctl`

## Requirements
- R1: After reset the mode is outside (0), the depth is 0, the status word and the failing address are 0, and rsp_valid and redirect_o are low.
- R2: A begin (op 1) issued outside starts a transaction. One cycle later the mode is inside (1), the depth is 1, rsp_cc is 4'b0001 (bit 0 = executed in a transaction) and handler_o is the begin address plus 4.
- R3: A begin issued inside raises the depth by one, returns rsp_cc 4'b0001 and leaves handler_o unchanged. Depth can reach MAX_NEST (31).
- R4: An end (op 2) issued inside lowers the depth by one and returns rsp_cc 4'b0001. At depth 1 it commits: the mode becomes outside and the depth 0.
- R5: An end issued outside returns rsp_cc 4'b0010 (bit 1 = extraneous) and changes no mode, depth or status.
- R6: A begin issued inside at depth MAX_NEST is a failure with cause 7. The status word becomes 12'hF00 and the failing address is the begin's address.
- R7: Both unconditional aborts fail the transaction: op 3 records code 0 and op 4 records cmd_code. The status is {persistent=0, cause=2, code}. One cycle later redirect_o is high, redirect_addr_o equals handler_o, the mode is outside, the depth is 0 and rsp_cc is 4'b1000 (bit 3 = failure return). Aborts issued outside a transaction only return rsp_cc 0.
- R8: A conditional abort (op 5) compares cmd_a with cmd_b. cmd_cond selects the test: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 and 7 never. When cmd_wide is 0, only the low half of each operand is compared, with that half's own sign. The abort fails the transaction (cause 2, code 0) only when the test holds.
- R9: Suspend (op 6) moves inside to suspended (2) and resume (op 7) moves suspended back to inside, each returning rsp_cc 4'b0001. A begin while suspended returns rsp_cc 0 and changes nothing. Suspend issued outside returns rsp_cc 0.
- R10: A failure event while suspended updates the status word and failing address one cycle later, with no redirect. The following resume redirects to the handler with rsp_cc 4'b1000 and the mode becomes outside.
- R11: A failure event (evt_cause nonzero) while inside redirects one cycle later to handler_o. The failing address is evt_pc.
- R12: The status word is {bit 11 persistent, bits 10:8 cause, bits 7:0 code}. Causes are encoded as: 1 conflict, 2 abort, 3 footprint, 4 I/O, 5 non-write-back access, 6 disallowed instruction, 7 nesting overflow. Causes 3 to 7 are persistent; causes 1 and 2 are transient.
- R13: Only the first failure after an outermost begin is latched; later events leave the status word unchanged. A check (op 8) returns bit 0 when inside or suspended and bit 2 when the suspended transaction has already failed.
- R14: Failure events while outside are ignored: the status word is unchanged and there is no response or redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode (1 begin … 8 check) |
| cmd_pc | input | AW | Instruction address of the command |
| cmd_code | input | 8 | Software code for the coded abort |
| cmd_cond | input | 3 | Conditional abort test select |
| cmd_wide | input | 1 | 1: full-width compare, 0: low half |
| cmd_a | input | DW | First compare operand |
| cmd_b | input | DW | Second operand (register or extended immediate) |
| evt_valid | input | 1 | External failure event |
| evt_cause | input | 3 | Cause of the event |
| evt_pc | input | AW | Address tied to the event |
| mode_o | output | 2 | 0 outside, 1 inside, 2 suspended |
| depth_o | output | DEPTH_W | Nesting depth |
| handler_o | output | AW | Failure handler address |
| fail_addr_o | output | AW | Address of the failing instruction |
| status_o | output | 12 | Persistent hint, cause, software code |
| rsp_valid | output | 1 | Condition result valid |
| rsp_cc | output | 4 | Condition result bits |
| redirect_o | output | 1 | Failure handling requested |
| redirect_addr_o | output | AW | Redirect target |

## Verification
A wrong mode or depth shows on mode_o and depth_o, and in the next command's condition result, one cycle after the command that caused it. A stale handler shows only when a failure redirects. A lost deferred failure stays hidden until the resume, which then fails to redirect. The sequences therefore end every suspended scenario with a resume. They drive the depth all the way to its limit, so that an off-by-one in the overflow test is seen on the very begin that should fail.

// File: rtl/txn_pkg.sv
package txn_pkg;

  typedef enum logic [1:0] {
    MODE_OUT  = 2'd0,
    MODE_IN   = 2'd1,
    MODE_SUSP = 2'd2
  } txn_mode_e;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_BEGIN     = 4'd1,
    OP_END       = 4'd2,
    OP_ABORT     = 4'd3,
    OP_ABORT_C   = 4'd4,
    OP_ABORT_IF  = 4'd5,
    OP_SUSPEND   = 4'd6,
    OP_RESUME    = 4'd7,
    OP_CHECK     = 4'd8
  } txn_op_e;

  typedef enum logic [2:0] {
    CS_NONE      = 3'd0,
    CS_CONFLICT  = 3'd1,
    CS_ABORT     = 3'd2,
    CS_FOOTPRINT = 3'd3,
    CS_IO        = 3'd4,
    CS_NONWB     = 3'd5,
    CS_DISALLOW  = 3'd6,
    CS_NEST_OVF  = 3'd7
  } txn_cause_e;

  localparam int CODE_W      = 8;
  localparam int STATUS_W    = 1 + 3 + CODE_W;
  localparam int CC_W        = 4;
  localparam int CC_IN_TXN   = 0;
  localparam int CC_EXTRA    = 1;
  localparam int CC_FAILED   = 2;
  localparam int CC_FAILRET  = 3;
  localparam int HANDLER_OFS = 4;

  typedef struct packed {
    logic              persistent;
    logic [2:0]        cause;
    logic [CODE_W-1:0] code;
  } txn_status_t;

  // Retry hint: causes that will repeat on a retry are marked persistent.
  function automatic logic cause_persistent(input logic [2:0] c);
    case (c)
      CS_FOOTPRINT, CS_IO, CS_NONWB, CS_DISALLOW, CS_NEST_OVF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/txn_cond_eval.sv
module txn_cond_eval #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [2:0]    cond_i,
  input  logic          wide_i,
  output logic          hit_o
);
  localparam int HW = DW / 2;

  function automatic logic [DW-1:0] ext(input logic [DW-1:0] v, input logic wide, input logic sgn);
    if (wide) return v;
    return {{HW{sgn & v[HW-1]}}, v[HW-1:0]};
  endfunction

  logic [DW-1:0] a_s, b_s, a_u, b_u;

  always_comb begin
    a_s = ext(a_i, wide_i, 1'b1);
    b_s = ext(b_i, wide_i, 1'b1);
    a_u = ext(a_i, wide_i, 1'b0);
    b_u = ext(b_i, wide_i, 1'b0);
    case (cond_i)
      3'd0:    hit_o = (a_u == b_u);
      3'd1:    hit_o = (a_u != b_u);
      3'd2:    hit_o = ($signed(a_s) < $signed(b_s));
      3'd3:    hit_o = ($signed(b_s) < $signed(a_s));
      3'd4:    hit_o = (a_u < b_u);
      3'd5:    hit_o = (b_u < a_u);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/txn_mode_nest.sv
module txn_mode_nest
  import txn_pkg::*;
#(
  parameter int MAX_NEST = 31,
  parameter int DEPTH_W  = $clog2(MAX_NEST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic               suspend_i,
  input  logic               resume_i,
  input  logic               unwind_i,
  output logic [1:0]         mode_o,
  output logic [DEPTH_W-1:0] depth_o
);
  logic [1:0]         mode_q;
  logic [DEPTH_W-1:0] depth_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_OUT;
      depth_q <= '0;
    end else if (unwind_i) begin
      mode_q  <= MODE_OUT;
      depth_q <= '0;
    end else if (start_i) begin
      mode_q  <= MODE_IN;
      depth_q <= DEPTH_W'(1);
    end else if (push_i) begin
      depth_q <= depth_q + DEPTH_W'(1);
    end else if (pop_i) begin
      if (depth_q == DEPTH_W'(1)) begin
        mode_q  <= MODE_OUT;
        depth_q <= '0;
      end else begin
        depth_q <= depth_q - DEPTH_W'(1);
      end
    end else if (suspend_i) begin
      mode_q <= MODE_SUSP;
    end else if (resume_i) begin
      mode_q <= MODE_IN;
    end
  end

  assign mode_o  = mode_q;
  assign depth_o = depth_q;
endmodule

// File: rtl/txn_fail_rec.sv
module txn_fail_rec
  import txn_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_i,
  input  logic [AW-1:0]       arm_pc_i,
  input  logic                rec_i,
  input  logic [2:0]          cause_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [AW-1:0]       rec_pc_i,
  output logic [AW-1:0]       handler_o,
  output logic [AW-1:0]       fail_addr_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                failed_o
);
  logic [AW-1:0] handler_q, fail_q;
  txn_status_t   status_q;
  logic          failed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      handler_q <= '0;
      fail_q    <= '0;
      status_q  <= '0;
      failed_q  <= 1'b0;
    end else begin
      if (arm_i) begin
        handler_q <= arm_pc_i + AW'(HANDLER_OFS);
        failed_q  <= 1'b0;
      end
      if (rec_i) begin
        status_q.persistent <= cause_persistent(cause_i);
        status_q.cause      <= cause_i;
        status_q.code       <= code_i;
        fail_q              <= rec_pc_i;
        failed_q            <= 1'b1;
      end
    end
  end

  assign handler_o   = handler_q;
  assign fail_addr_o = fail_q;
  assign status_o    = status_q;
  assign failed_o    = failed_q;
endmodule

// File: rtl/txn_ctl.sv
module txn_ctl
  import txn_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int MAX_NEST = 31,
  parameter int DEPTH_W  = $clog2(MAX_NEST + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [3:0]          cmd_op,
  input  logic [AW-1:0]       cmd_pc,
  input  logic [CODE_W-1:0]   cmd_code,
  input  logic [2:0]          cmd_cond,
  input  logic                cmd_wide,
  input  logic [DW-1:0]       cmd_a,
  input  logic [DW-1:0]       cmd_b,
  input  logic                evt_valid,
  input  logic [2:0]          evt_cause,
  input  logic [AW-1:0]       evt_pc,
  output logic [1:0]          mode_o,
  output logic [DEPTH_W-1:0]  depth_o,
  output logic [AW-1:0]       handler_o,
  output logic [AW-1:0]       fail_addr_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                rsp_valid,
  output logic [CC_W-1:0]     rsp_cc,
  output logic                redirect_o,
  output logic [AW-1:0]       redirect_addr_o
);
  // Named internal events (also observed by the bound checker)
  logic is_out, is_in, is_susp;
  logic op_begin, op_end, op_abort, op_abort_c, op_abort_if;
  logic op_susp, op_resume, op_check;
  logic cond_hit, nest_ovf, cmd_fail;
  logic evt_in_t, evt_in_s, resume_fail, handle_w;
  logic rec_w, failed_w;
  logic [2:0]        rec_cause;
  logic [CODE_W-1:0] rec_code;
  logic [AW-1:0]     rec_pc;
  logic [CC_W-1:0]   cc_d;

  function automatic logic is_op(input logic v, input logic [3:0] op, input txn_op_e want);
    return v && (op == want);
  endfunction

  txn_cond_eval #(.DW(DW)) u_cond (
    .a_i(cmd_a), .b_i(cmd_b), .cond_i(cmd_cond), .wide_i(cmd_wide), .hit_o(cond_hit)
  );

  always_comb begin
    is_out  = (mode_o == MODE_OUT);
    is_in   = (mode_o == MODE_IN);
    is_susp = (mode_o == MODE_SUSP);

    op_begin    = is_op(cmd_valid, cmd_op, OP_BEGIN);
    op_end      = is_op(cmd_valid, cmd_op, OP_END);
    op_abort    = is_op(cmd_valid, cmd_op, OP_ABORT);
    op_abort_c  = is_op(cmd_valid, cmd_op, OP_ABORT_C);
    op_abort_if = is_op(cmd_valid, cmd_op, OP_ABORT_IF);
    op_susp     = is_op(cmd_valid, cmd_op, OP_SUSPEND);
    op_resume   = is_op(cmd_valid, cmd_op, OP_RESUME);
    op_check    = is_op(cmd_valid, cmd_op, OP_CHECK);

    nest_ovf = op_begin && is_in && (depth_o == DEPTH_W'(MAX_NEST));
    cmd_fail = nest_ovf ||
               (is_in && (op_abort || op_abort_c || (op_abort_if && cond_hit)));

    evt_in_t    = evt_valid && (evt_cause != CS_NONE) && is_in;
    evt_in_s    = evt_valid && (evt_cause != CS_NONE) && is_susp && !failed_w;
    resume_fail = op_resume && is_susp && (failed_w || evt_in_s);
    handle_w    = evt_in_t || cmd_fail || resume_fail;

    rec_w     = evt_in_t || evt_in_s || cmd_fail;
    rec_cause = (evt_in_t || evt_in_s) ? evt_cause : (nest_ovf ? CS_NEST_OVF : CS_ABORT);
    rec_code  = (!evt_in_t && op_abort_c) ? cmd_code : '0;
    rec_pc    = (evt_in_t || evt_in_s) ? evt_pc : cmd_pc;

    cc_d = '0;
    if (handle_w) begin
      cc_d[CC_FAILRET] = 1'b1;
    end else begin
      case (cmd_op)
        OP_BEGIN:   cc_d[CC_IN_TXN] = is_out || is_in;
        OP_END: begin
          cc_d[CC_IN_TXN] = is_in;
          cc_d[CC_EXTRA]  = is_out;
        end
        OP_SUSPEND: cc_d[CC_IN_TXN] = is_in;
        OP_RESUME:  cc_d[CC_IN_TXN] = is_susp;
        OP_CHECK: begin
          cc_d[CC_IN_TXN] = is_in || is_susp;
          cc_d[CC_FAILED] = is_susp && (failed_w || evt_in_s);
        end
        default:    cc_d = '0;
      endcase
    end
  end

  txn_mode_nest #(.MAX_NEST(MAX_NEST), .DEPTH_W(DEPTH_W)) u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (op_begin && is_out),
    .push_i    (op_begin && is_in && !nest_ovf),
    .pop_i     (op_end && is_in),
    .suspend_i (op_susp && is_in),
    .resume_i  (op_resume && is_susp && !resume_fail),
    .unwind_i  (handle_w),
    .mode_o    (mode_o),
    .depth_o   (depth_o)
  );

  txn_fail_rec #(.AW(AW)) u_rec (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (op_begin && is_out),
    .arm_pc_i    (cmd_pc),
    .rec_i       (rec_w),
    .cause_i     (rec_cause),
    .code_i      (rec_code),
    .rec_pc_i    (rec_pc),
    .handler_o   (handler_o),
    .fail_addr_o (fail_addr_o),
    .status_o    (status_o),
    .failed_o    (failed_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_cc          <= '0;
      redirect_o      <= 1'b0;
      redirect_addr_o <= '0;
    end else begin
      rsp_valid       <= cmd_valid || handle_w;
      rsp_cc          <= cc_d;
      redirect_o      <= handle_w;
      redirect_addr_o <= handle_w ? handler_o : redirect_addr_o;
    end
  end
endmodule

// File: rtl/txn_ctl_chk.sv
module txn_ctl_chk #(
  parameter int AW       = 32,
  parameter int MAX_NEST = 31,
  parameter int DEPTH_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic [AW-1:0]      handler_o,
  input logic [11:0]        status_o,
  input logic               rsp_valid,
  input logic [3:0]         rsp_cc,
  input logic               redirect_o,
  input logic [AW-1:0]      redirect_addr_o,
  input logic               failed_w
);
  p_unwind_on_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (mode_o == 2'd0) && (depth_o == '0) && rsp_valid && (rsp_cc == 4'b1000));

  p_redirect_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (redirect_addr_o == handler_o));

  p_idle_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (depth_o == '0));

  p_active_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |-> (depth_o != '0) && (depth_o <= DEPTH_W'(MAX_NEST)));

  p_extraneous_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cc[1]) |-> (mode_o == 2'd0) && $stable(status_o) && !redirect_o);

  p_first_cause_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 2'd2) && ($past(mode_o) == 2'd2) && $past(failed_w)) |-> $stable(status_o));

  p_suspend_defers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 2'd2) && ($past(mode_o) == 2'd2)) |-> !redirect_o);

  p_overflow_persistent_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[10:8] == 3'd7) |-> status_o[11]);

  p_conflict_transient_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[10:8] == 3'd1) |-> !status_o[11]);
endmodule

bind txn_ctl txn_ctl_chk #(.AW(AW), .MAX_NEST(MAX_NEST), .DEPTH_W(DEPTH_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_o          (mode_o),
  .depth_o         (depth_o),
  .handler_o       (handler_o),
  .status_o        (status_o),
  .rsp_valid       (rsp_valid),
  .rsp_cc          (rsp_cc),
  .redirect_o      (redirect_o),
  .redirect_addr_o (redirect_addr_o),
  .failed_w        (failed_w)
);

// File: tb/tb_txn_ctl.sv
`timescale 1ns/1ps
module tb_txn_ctl;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int MAXN = 31;
  localparam int DEPW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [AW-1:0] cmd_pc = '0;
  logic [7:0] cmd_code = '0;
  logic [2:0] cmd_cond = '0;
  logic cmd_wide = 1'b1;
  logic [DW-1:0] cmd_a = '0, cmd_b = '0;
  logic evt_valid = 1'b0;
  logic [2:0] evt_cause = '0;
  logic [AW-1:0] evt_pc = '0;
  logic [1:0] mode_o;
  logic [DEPW-1:0] depth_o;
  logic [AW-1:0] handler_o, fail_addr_o, redirect_addr_o;
  logic [11:0] status_o;
  logic rsp_valid, redirect_o;
  logic [3:0] rsp_cc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  txn_ctl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pc(cmd_pc),
    .cmd_code(cmd_code), .cmd_cond(cmd_cond), .cmd_wide(cmd_wide), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .evt_valid(evt_valid), .evt_cause(evt_cause), .evt_pc(evt_pc),
    .mode_o(mode_o), .depth_o(depth_o), .handler_o(handler_o), .fail_addr_o(fail_addr_o),
    .status_o(status_o), .rsp_valid(rsp_valid), .rsp_cc(rsp_cc),
    .redirect_o(redirect_o), .redirect_addr_o(redirect_addr_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Status expectation written from the cause classes in the requirements.
  function automatic logic [11:0] exp_status(input logic [2:0] cause, input logic [7:0] code);
    logic hint;
    hint = (cause >= 3'd3);
    return {hint, cause, code};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    evt_valid = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] op, input logic [AW-1:0] pc);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_pc = pc;
    step();
  endtask

  task automatic evt(input logic [2:0] cause, input logic [AW-1:0] pc);
    evt_valid = 1'b1;
    evt_cause = cause;
    evt_pc = pc;
    step();
  endtask

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] pc;
    logic        ev;
    logic [2:0]  cause;
    logic [1:0]  mode;
    logic [4:0]  depth;
    logic        rsp;
    logic [3:0]  cc;
    logic        redir;
  } row_t;

  localparam int NROW = 16;
  localparam row_t TBL [NROW] = '{
    '{4'd1, 32'h100, 1'b0, 3'd0, 2'd1, 5'd1, 1'b1, 4'd1, 1'b0},
    '{4'd1, 32'h200, 1'b0, 3'd0, 2'd1, 5'd2, 1'b1, 4'd1, 1'b0},
    '{4'd2, 32'h204, 1'b0, 3'd0, 2'd1, 5'd1, 1'b1, 4'd1, 1'b0},
    '{4'd8, 32'h208, 1'b0, 3'd0, 2'd1, 5'd1, 1'b1, 4'd1, 1'b0},
    '{4'd2, 32'h20C, 1'b0, 3'd0, 2'd0, 5'd0, 1'b1, 4'd1, 1'b0},
    '{4'd2, 32'h210, 1'b0, 3'd0, 2'd0, 5'd0, 1'b1, 4'd2, 1'b0},
    '{4'd8, 32'h214, 1'b0, 3'd0, 2'd0, 5'd0, 1'b1, 4'd0, 1'b0},
    '{4'd1, 32'h300, 1'b0, 3'd0, 2'd1, 5'd1, 1'b1, 4'd1, 1'b0},
    '{4'd6, 32'h304, 1'b0, 3'd0, 2'd2, 5'd1, 1'b1, 4'd1, 1'b0},
    '{4'd1, 32'h400, 1'b0, 3'd0, 2'd2, 5'd1, 1'b1, 4'd0, 1'b0},
    '{4'd7, 32'h308, 1'b0, 3'd0, 2'd1, 5'd1, 1'b1, 4'd1, 1'b0},
    '{4'd0, 32'h0,   1'b1, 3'd1, 2'd0, 5'd0, 1'b1, 4'd8, 1'b1},
    '{4'd0, 32'h0,   1'b1, 3'd6, 2'd0, 5'd0, 1'b0, 4'd0, 1'b0},
    '{4'd3, 32'h500, 1'b0, 3'd0, 2'd0, 5'd0, 1'b1, 4'd0, 1'b0},
    '{4'd6, 32'h504, 1'b0, 3'd0, 2'd0, 5'd0, 1'b1, 4'd0, 1'b0},
    '{4'd7, 32'h508, 1'b0, 3'd0, 2'd0, 5'd0, 1'b1, 4'd0, 1'b0}
  };

  function automatic string row_req(input int i);
    case (i)
      0, 7:        return "R2";
      1:           return "R3";
      2, 4:        return "R4";
      5:           return "R5";
      3, 6:        return "R13";
      8, 9, 10, 14, 15: return "R9";
      11:          return "R11";
      12:          return "R14";
      default:     return "R7";
    endcase
  endfunction

  typedef struct packed {
    logic [2:0]  cond;
    logic        wide;
    logic [63:0] a;
    logic [63:0] b;
    logic        hit;
  } cmp_t;

  localparam int NCMP = 10;
  localparam cmp_t CMP [NCMP] = '{
    '{3'd0, 1'b1, 64'd5, 64'd5, 1'b1},
    '{3'd1, 1'b1, 64'd5, 64'd5, 1'b0},
    '{3'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1},
    '{3'd4, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0},
    '{3'd2, 1'b0, 64'h0000_0001_8000_0000, 64'd0, 1'b1},
    '{3'd2, 1'b1, 64'h0000_0001_8000_0000, 64'd0, 1'b0},
    '{3'd0, 1'b0, 64'hFFFF_0000_0000_0007, 64'd7, 1'b1},
    '{3'd5, 1'b0, 64'h0000_0001_0000_0000, 64'd0, 1'b0},
    '{3'd3, 1'b1, 64'd2, 64'd1, 1'b1},
    '{3'd6, 1'b1, 64'd0, 64'd0, 1'b0}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "mode", 64'(mode_o), 64'd0);
    chk("R1", "depth", 64'(depth_o), 64'd0);
    chk("R1", "status", 64'(status_o), 64'd0);
    chk("R1", "fail_addr", 64'(fail_addr_o), 64'd0);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "redirect", 64'(redirect_o), 64'd0);

    // Table walk
    for (int i = 0; i < NROW; i++) begin
      cmd_valid = (TBL[i].op != 4'd0);
      cmd_op    = TBL[i].op;
      cmd_pc    = TBL[i].pc;
      evt_valid = TBL[i].ev;
      evt_cause = TBL[i].cause;
      evt_pc    = 32'h3A0;
      step();
      chk(row_req(i), $sformatf("row %0d mode", i), 64'(mode_o), 64'(TBL[i].mode));
      chk(row_req(i), $sformatf("row %0d depth", i), 64'(depth_o), 64'(TBL[i].depth));
      chk(row_req(i), $sformatf("row %0d rsp_valid", i), 64'(rsp_valid), 64'(TBL[i].rsp));
      if (TBL[i].rsp)
        chk(row_req(i), $sformatf("row %0d cc", i), 64'(rsp_cc), 64'(TBL[i].cc));
      chk(row_req(i), $sformatf("row %0d redirect", i), 64'(redirect_o), 64'(TBL[i].redir));
      if (i == 0) chk("R2", "handler", 64'(handler_o), 64'h104);
      if (i == 1) chk("R3", "handler kept", 64'(handler_o), 64'h104);
      if (i == 11) chk("R11", "redirect addr", 64'(redirect_addr_o), 64'h304);
    end
    chk("R11", "fail addr from event", 64'(fail_addr_o), 64'h3A0);
    chk("R14", "status after ignored event", 64'(status_o), 64'(exp_status(3'd1, 8'h00)));

    // R3/R6 nesting up to the limit and one past it
    cmd(4'd1, 32'h1000);
    for (int k = 0; k < MAXN - 1; k++) cmd(4'd1, 32'h1100 + 32'(k * 4));
    chk("R3", "depth at limit", 64'(depth_o), 64'(MAXN));
    chk("R3", "mode at limit", 64'(mode_o), 64'd1);
    cmd(4'd1, 32'h2000);
    chk("R6", "redirect", 64'(redirect_o), 64'd1);
    chk("R6", "redirect addr", 64'(redirect_addr_o), 64'h1004);
    chk("R6", "status", 64'(status_o), 64'hF00);
    chk("R6", "fail addr", 64'(fail_addr_o), 64'h2000);
    chk("R6", "depth", 64'(depth_o), 64'd0);

    // R7 coded and plain aborts
    cmd(4'd1, 32'h500);
    cmd_code = 8'hA5;
    cmd(4'd4, 32'h520);
    cmd_code = 8'h00;
    chk("R7", "redirect", 64'(redirect_o), 64'd1);
    chk("R7", "redirect addr", 64'(redirect_addr_o), 64'h504);
    chk("R7", "cc", 64'(rsp_cc), 64'h8);
    chk("R7", "status coded", 64'(status_o), 64'(exp_status(3'd2, 8'hA5)));
    chk("R7", "fail addr", 64'(fail_addr_o), 64'h520);
    cmd(4'd1, 32'h600);
    cmd_code = 8'h3C;
    cmd(4'd3, 32'h610);
    cmd_code = 8'h00;
    chk("R7", "status plain", 64'(status_o), 64'(exp_status(3'd2, 8'h00)));
    chk("R7", "mode after abort", 64'(mode_o), 64'd0);

    // R8 conditional aborts
    for (int c = 0; c < NCMP; c++) begin
      cmd(4'd1, 32'h800);
      cmd_cond = CMP[c].cond;
      cmd_wide = CMP[c].wide;
      cmd_a    = CMP[c].a;
      cmd_b    = CMP[c].b;
      cmd(4'd5, 32'h810);
      chk("R8", $sformatf("case %0d redirect", c), 64'(redirect_o), 64'(CMP[c].hit));
      if (CMP[c].hit) begin
        chk("R8", $sformatf("case %0d status", c), 64'(status_o), 64'(exp_status(3'd2, 8'h00)));
      end else begin
        chk("R8", $sformatf("case %0d mode", c), 64'(mode_o), 64'd1);
        cmd(4'd2, 32'h820);
      end
    end

    // R10/R13 deferred failure while suspended
    cmd(4'd1, 32'h700);
    cmd(4'd6, 32'h708);
    evt(3'd3, 32'h7F0);
    chk("R10", "mode still suspended", 64'(mode_o), 64'd2);
    chk("R10", "no redirect", 64'(redirect_o), 64'd0);
    chk("R10", "status recorded", 64'(status_o), 64'(exp_status(3'd3, 8'h00)));
    evt(3'd1, 32'h7F8);
    chk("R13", "first cause kept", 64'(status_o), 64'(exp_status(3'd3, 8'h00)));
    chk("R13", "fail addr kept", 64'(fail_addr_o), 64'h7F0);
    cmd(4'd8, 32'h70C);
    chk("R13", "check cc", 64'(rsp_cc), 64'h5);
    cmd(4'd7, 32'h710);
    chk("R10", "resume redirect", 64'(redirect_o), 64'd1);
    chk("R10", "resume addr", 64'(redirect_addr_o), 64'h704);
    chk("R10", "resume cc", 64'(rsp_cc), 64'h8);
    chk("R10", "mode after resume", 64'(mode_o), 64'd0);

    // R12 persistence classes
    for (int c = 4; c <= 6; c++) begin
      cmd(4'd1, 32'h900);
      evt(3'(c), 32'h940);
      chk("R12", $sformatf("cause %0d status", c), 64'(status_o), 64'(exp_status(3'(c), 8'h00)));
    end

    // R14 event outside
    evt(3'd7, 32'h990);
    chk("R14", "status unchanged", 64'(status_o), 64'(exp_status(3'd6, 8'h00)));
    chk("R14", "no rsp", 64'(rsp_valid), 64'd0);

    finish_run();
  end
endmodule